// File: doc/BRIEF.md
# Interleaved Dual-Lane Fetch Sequencer

This block produces fetch addresses for a single thread that runs on two pipelines joined side by side. In joined mode the dynamic instruction stream is dealt out alternately: lane 0 takes the first instruction, lane 1 the second, lane 0 the third, and so on. Each lane carries a program-order sequence number with its address, so the instructions can be put back in order downstream. In single mode lane 0 fetches every instruction and lane 1 stays idle.

Each lane owns a private gshare direction predictor: a 16-bit global history register and a table of 2-bit saturating counters. Resolved branches are broadcast to both lanes in the same cycle, so the two tables take identical updates in identical order and never diverge. Neither lane reads the other's state. A resolved mispredict redirects both lanes to the same target in the same cycle, and the alternation restarts with lane 0 holding the target instruction. The mode is captured only at reset and on a redirect, so the two lanes always agree on the stride.

Top module: `ilv_fetch_seq`

## Requirements
- R1: In the first cycle after reset release, lane 0 shows valid, address RESET_PC, sequence 0 and prediction 0. Lane 1 shows address RESET_PC+4 and sequence 1, and its valid equals the mode captured in reset (1 means joined).
- R2: In joined mode both lanes are valid. Each cycle with `advance` high and no redirect adds 8 to both addresses and 2 to both sequence numbers.
- R3: In single mode `f1_valid` is 0. Each cycle with `advance` high and no redirect adds 4 to lane 0's address and 1 to its sequence number.
- R4: With `advance` low and no redirect, addresses and sequence numbers hold.
- R5: A redirect is `rs_valid` and `rs_mispred` both high. In the next cycle lane 0 shows `rs_target` with sequence `rs_seq`+1 and lane 1 shows `rs_target`+4 with sequence `rs_seq`+2. A redirect takes priority over `advance`.
- R6: The mode is taken from `joined` only at reset and on a redirect. A change of `joined` at any other time has no effect on `f1_valid` or on the stride.
- R7: A lane's prediction is bit 1 of the 2-bit counter at index pc[IDX_W+1:2] XOR history[IDX_W-1:0]. Every counter resets to 01 and the history resets to 0.
- R8: On `rs_valid`, the counter indexed by `rs_pc` under the current history moves up by one toward a ceiling of 3 when `rs_taken` is 1, and down by one toward a floor of 0 otherwise. The history then shifts left, taking `rs_taken` into bit 0.
- R9: The two lanes' history registers and counter tables are equal in every cycle, so both lanes' predictions follow R7 and R8 on one shared model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| joined | input | 1 | Requested mode, 1 joined, 0 single; captured at reset and on redirect |
| advance | input | 1 | Step the fetch stream this cycle |
| rs_valid | input | 1 | A branch resolved this cycle |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_seq | input | SEQ_W | Sequence number of the resolved branch |
| rs_taken | input | 1 | Resolved direction |
| rs_mispred | input | 1 | Resolved branch was mispredicted; redirect |
| rs_target | input | PC_W | Correct next address after the branch |
| f0_valid | output | 1 | Lane 0 slot valid |
| f0_pc | output | PC_W | Lane 0 fetch address |
| f0_seq | output | SEQ_W | Lane 0 program-order sequence number |
| f0_pred | output | 1 | Lane 0 predicted direction |
| f1_valid | output | 1 | Lane 1 slot valid (joined mode) |
| f1_pc | output | PC_W | Lane 1 fetch address |
| f1_seq | output | SEQ_W | Lane 1 program-order sequence number |
| f1_pred | output | 1 | Lane 1 predicted direction |

## Verification
The bench goes after the redirect point. A design that kept the old parity, or gave lane 1 the target, would put instructions out of order. It also tries mode changes without a redirect; a block that followed `joined` at once would have the lanes disagree on the stride. Counter saturation is driven with long runs of one direction and then a single reversal at an index placed under the lane's next lookup, so a wrapping counter shows up as a wrong prediction. A long pseudo-random phase mixes resolves, stalls and redirects and compares both lanes' predictions with one shared model. A table that one lane updates differently from the other therefore shows up as a lane disagreeing with the model.

// File: rtl/ilv_fetch_seq.sv
module ilv_fetch_seq #(
  parameter int PC_W = 32,
  parameter int SEQ_W = 16,
  parameter int GHR_W = 16,
  parameter int IDX_W = 8,
  parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             joined,
  input  logic             advance,
  input  logic             rs_valid,
  input  logic [PC_W-1:0]  rs_pc,
  input  logic [SEQ_W-1:0] rs_seq,
  input  logic             rs_taken,
  input  logic             rs_mispred,
  input  logic [PC_W-1:0]  rs_target,
  output logic             f0_valid,
  output logic [PC_W-1:0]  f0_pc,
  output logic [SEQ_W-1:0] f0_seq,
  output logic             f0_pred,
  output logic             f1_valid,
  output logic [PC_W-1:0]  f1_pc,
  output logic [SEQ_W-1:0] f1_seq,
  output logic             f1_pred
);
  localparam int LANES = 2;
  localparam int ENT = 1 << IDX_W;

  logic mode_q, run_q;
  wire redir = rs_valid & rs_mispred;
  wire [PC_W-1:0]  step_pc  = mode_q ? PC_W'(8) : PC_W'(4);
  wire [SEQ_W-1:0] step_seq = mode_q ? SEQ_W'(2) : SEQ_W'(1);

  logic [LANES*PC_W-1:0]  pc_all;
  logic [LANES*SEQ_W-1:0] seq_all;
  logic [LANES*GHR_W-1:0] ghr_all;
  logic [LANES*2*ENT-1:0] pht_all;
  logic [LANES-1:0]       pred_all;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= joined;
      run_q  <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (redir) mode_q <= joined;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : lane
    localparam logic [PC_W-1:0] OFS = PC_W'(4 * g);
    logic [PC_W-1:0]  pc_r;
    logic [SEQ_W-1:0] seq_r;
    logic [GHR_W-1:0] ghr_r;
    logic [2*ENT-1:0] pht_r;
    logic [IDX_W-1:0] upd_idx, look_idx;
    logic [1:0]       ctr, ctr_nxt;

    assign upd_idx  = rs_pc[IDX_W+1:2] ^ ghr_r[IDX_W-1:0];
    assign look_idx = pc_r[IDX_W+1:2] ^ ghr_r[IDX_W-1:0];
    assign ctr      = pht_r[2*upd_idx +: 2];

    always_comb begin
      ctr_nxt = ctr;
      if (rs_taken && ctr != 2'b11) ctr_nxt = ctr + 2'b01;
      else if (!rs_taken && ctr != 2'b00) ctr_nxt = ctr - 2'b01;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pc_r  <= RESET_PC[PC_W-1:0] + OFS;
        seq_r <= SEQ_W'(g);
      end else if (redir) begin
        pc_r  <= rs_target + OFS;
        seq_r <= rs_seq + SEQ_W'(g + 1);
      end else if (advance) begin
        pc_r  <= pc_r + step_pc;
        seq_r <= seq_r + step_seq;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ghr_r <= '0;
        pht_r <= {ENT{2'b01}};
      end else if (rs_valid) begin
        ghr_r <= {ghr_r[GHR_W-2:0], rs_taken};
        pht_r[2*upd_idx +: 2] <= ctr_nxt;
      end
    end

    assign pc_all[g*PC_W +: PC_W]     = pc_r;
    assign seq_all[g*SEQ_W +: SEQ_W]  = seq_r;
    assign ghr_all[g*GHR_W +: GHR_W]  = ghr_r;
    assign pht_all[g*2*ENT +: 2*ENT]  = pht_r;
    assign pred_all[g]                = pht_r[2*look_idx + 1];
  end

  assign f0_valid = run_q;
  assign f1_valid = run_q & mode_q;
  assign f0_pc    = pc_all[0 +: PC_W];
  assign f1_pc    = pc_all[PC_W +: PC_W];
  assign f0_seq   = seq_all[0 +: SEQ_W];
  assign f1_seq   = seq_all[SEQ_W +: SEQ_W];
  assign f0_pred  = pred_all[0];
  assign f1_pred  = pred_all[1];
endmodule

module ilv_fetch_seq_chk #(
  parameter int PC_W = 32,
  parameter int SEQ_W = 16,
  parameter int GHR_W = 16,
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             advance,
  input logic             rs_valid,
  input logic             rs_mispred,
  input logic [PC_W-1:0]  rs_target,
  input logic [SEQ_W-1:0] rs_seq,
  input logic             f0_valid,
  input logic [PC_W-1:0]  f0_pc,
  input logic [SEQ_W-1:0] f0_seq,
  input logic             f1_valid,
  input logic [PC_W-1:0]  f1_pc,
  input logic [SEQ_W-1:0] f1_seq,
  input logic [2*GHR_W-1:0] ghr_both,
  input logic [4*(1<<IDX_W)-1:0] pht_both
);
  localparam int TW = 2 * (1 << IDX_W);

  // R9
  copies_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ghr_both[0 +: GHR_W] == ghr_both[GHR_W +: GHR_W] && pht_both[0 +: TW] == pht_both[TW +: TW]);

  // R5
  redirect_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && rs_mispred |=> f0_pc == $past(rs_target) && f0_seq == $past(rs_seq) + SEQ_W'(1)
                               && f1_pc == $past(rs_target) + PC_W'(4) && f1_seq == $past(rs_seq) + SEQ_W'(2));

  // R2
  joined_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f1_valid && advance && !(rs_valid && rs_mispred) |=>
      f1_valid && f0_pc == $past(f0_pc) + PC_W'(8) && f1_seq == $past(f1_seq) + SEQ_W'(2));

  // R3
  single_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f0_valid && !f1_valid && advance && !(rs_valid && rs_mispred) |=>
      !f1_valid && f0_pc == $past(f0_pc) + PC_W'(4) && f0_seq == $past(f0_seq) + SEQ_W'(1));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f0_valid && !advance && !(rs_valid && rs_mispred) |=> $stable(f0_pc) && $stable(f0_seq));

  // R6
  mode_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f0_valid && !(rs_valid && rs_mispred) |=> f1_valid == $past(f1_valid));
endmodule

bind ilv_fetch_seq ilv_fetch_seq_chk #(.PC_W(PC_W), .SEQ_W(SEQ_W), .GHR_W(GHR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .advance(advance), .rs_valid(rs_valid), .rs_mispred(rs_mispred),
  .rs_target(rs_target), .rs_seq(rs_seq), .f0_valid(f0_valid), .f0_pc(f0_pc), .f0_seq(f0_seq),
  .f1_valid(f1_valid), .f1_pc(f1_pc), .f1_seq(f1_seq), .ghr_both(ghr_all), .pht_both(pht_all));

// File: tb/tb_ilv_fetch_seq.sv
module tb_ilv_fetch_seq;
  localparam int PC_W = 32;
  localparam int SEQ_W = 16;
  localparam int GHR_W = 16;
  localparam int IDX_W = 8;
  localparam int ENT = 1 << IDX_W;
  localparam logic [31:0] RPC = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic joined = 1'b1, advance = 1'b0, rs_valid = 1'b0, rs_taken = 1'b0, rs_mispred = 1'b0;
  logic [PC_W-1:0] rs_pc = '0, rs_target = '0;
  logic [SEQ_W-1:0] rs_seq = '0;
  logic f0_valid, f0_pred, f1_valid, f1_pred;
  logic [PC_W-1:0] f0_pc, f1_pc;
  logic [SEQ_W-1:0] f0_seq, f1_seq;

  always #2.5 clk = ~clk;

  ilv_fetch_seq dut (
    .clk(clk), .rst_n(rst_n), .joined(joined), .advance(advance), .rs_valid(rs_valid),
    .rs_pc(rs_pc), .rs_seq(rs_seq), .rs_taken(rs_taken), .rs_mispred(rs_mispred),
    .rs_target(rs_target), .f0_valid(f0_valid), .f0_pc(f0_pc), .f0_seq(f0_seq), .f0_pred(f0_pred),
    .f1_valid(f1_valid), .f1_pc(f1_pc), .f1_seq(f1_seq), .f1_pred(f1_pred));

  int n_chk = 0, n_bad = 0;
  logic [1:0] mpht [ENT];
  logic [GHR_W-1:0] mghr;
  logic mmode;
  logic [PC_W-1:0] mpc;
  logic [SEQ_W-1:0] mseq;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic mpred(logic [PC_W-1:0] pc);
    logic [IDX_W-1:0] i;
    i = pc[IDX_W+1:2] ^ mghr[IDX_W-1:0];
    return mpht[i][1];
  endfunction

  task automatic model_step();
    logic [IDX_W-1:0] i;
    if (rs_valid) begin
      i = rs_pc[IDX_W+1:2] ^ mghr[IDX_W-1:0];
      if (rs_taken && mpht[i] != 2'b11) mpht[i] = mpht[i] + 2'b01;
      else if (!rs_taken && mpht[i] != 2'b00) mpht[i] = mpht[i] - 2'b01;
      mghr = {mghr[GHR_W-2:0], rs_taken};
    end
    if (rs_valid && rs_mispred) begin
      mmode = joined;
      mpc = rs_target;
      mseq = rs_seq + SEQ_W'(1);
    end else if (advance) begin
      mpc = mpc + (mmode ? PC_W'(8) : PC_W'(4));
      mseq = mseq + (mmode ? SEQ_W'(2) : SEQ_W'(1));
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " f0_valid"}, 64'(f0_valid), 64'(1));
    chk({tag, " f0_pc"}, 64'(f0_pc), 64'(mpc));
    chk({tag, " f0_seq"}, 64'(f0_seq), 64'(mseq));
    chk({tag, " R7 f0_pred"}, 64'(f0_pred), 64'(mpred(mpc)));
    chk({tag, " R6 f1_valid"}, 64'(f1_valid), 64'(mmode));
    if (mmode) begin
      chk({tag, " f1_pc"}, 64'(f1_pc), 64'(mpc + PC_W'(4)));
      chk({tag, " f1_seq"}, 64'(f1_seq), 64'(mseq + SEQ_W'(1)));
      chk({tag, " R9 f1_pred"}, 64'(f1_pred), 64'(mpred(mpc + PC_W'(4))));
    end
  endtask

  task automatic cyc(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic quiet();
    advance = 1'b0; rs_valid = 1'b0; rs_mispred = 1'b0; rs_taken = 1'b0;
  endtask

  logic done = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    logic [PC_W-1:0] a;
    lf = 32'hACE1_2468;
    for (int i = 0; i < ENT; i++) mpht[i] = 2'b01;
    mghr = '0; mmode = 1'b1; mpc = RPC; mseq = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    quiet();
    // R1 reset state (first cycle after release)
    cyc("R1");
    // R2 joined stepping
    advance = 1'b1;
    for (int i = 0; i < 12; i++) cyc("R2");
    // R4 stalls interleaved
    for (int i = 0; i < 8; i++) begin advance = i[0]; cyc("R4"); end
    // R6 joined dropped without redirect: no effect
    joined = 1'b0; advance = 1'b1;
    for (int i = 0; i < 6; i++) cyc("R6");
    // R5 redirect into single mode, with advance high (priority)
    rs_valid = 1'b1; rs_mispred = 1'b1; rs_taken = 1'b1;
    rs_pc = mpc; rs_seq = mseq + SEQ_W'(1); rs_target = 32'h0000_2344;
    cyc("R5");
    rs_valid = 1'b0; rs_mispred = 1'b0;
    // R3 single-mode stepping; R6 raising joined is ignored
    joined = 1'b1;
    for (int i = 0; i < 10; i++) cyc("R3");
    // R5 redirect back to joined at an odd sequence point
    rs_valid = 1'b1; rs_mispred = 1'b1; rs_taken = 1'b0;
    rs_pc = mpc; rs_seq = 16'h7FFE; rs_target = 32'h0000_0FF0;
    cyc("R5");
    quiet();
    cyc("R5");
    // R8 saturation: long taken run, then one not-taken under the lane lookup
    a = mpc ^ PC_W'(4);
    rs_valid = 1'b1; rs_taken = 1'b1; rs_pc = a;
    for (int i = 0; i < 24; i++) cyc("R8");
    rs_taken = 1'b0;
    cyc("R8");
    chk("R8 saturated-high then one step down", 64'(f0_pred), 64'(1));
    rs_taken = 1'b0; rs_pc = mpc;
    for (int i = 0; i < 24; i++) cyc("R8");
    rs_taken = 1'b1; rs_pc = mpc;
    cyc("R8");
    quiet();
    cyc("R8");
    // R9 mixed pseudo-random traffic
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      advance = lf[3] | lf[7];
      rs_valid = lf[5];
      rs_taken = lf[9];
      rs_mispred = (lf[15:12] == 4'd0);
      joined = lf[17];
      rs_pc = lf[2] ? mpc : {20'h0, lf[27:18], 2'b00};
      rs_seq = mseq - SEQ_W'(lf[11:10]);
      rs_target = {16'h0, lf[29:16], 2'b00};
      cyc("R9");
    end
    quiet();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule